// File: doc/BRIEF.md
# Endpoint Buffer Command Controller

This block keeps the buffer-ownership state of sixteen USB device endpoints. A local CPU drives it with one-byte command codes. Index 0 is the control OUT endpoint and index 1 is the control IN endpoint. Indices 2 to 15 are general endpoints. The parameter `IN_MASK` sets the direction of each index (default `16'hAAAA`: odd indices are IN). The parameter `DBL_MASK` sets which indices have two buffers (default `16'hF000`: indices 12 to 15).

On the USB side there are two simple strobes. One reports a complete OUT packet and one reports a finished IN transmission. The block answers OUT traffic with a combinational accept/NAK signal that depends on the target endpoint's full flags. An OUT buffer stays locked until the CPU releases it. The CPU marks IN buffers as loaded, and the transmission strobe frees them. A status command returns a byte-wide image of one endpoint, and reading it does not disturb any state.

Top module: `ep_buf_cmd_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every endpoint's state is zero and `stat_valid` is 0. After reset, every status image reads 0x00.
- R2: A command code is decoded from its high nibble, and its low nibble is the endpoint index. 0x61–0x6F validate, 0x70 and 0x72–0x7F clear, and 0xD0–0xDF read status. All other codes cause no state change, including 0x60, 0x71, a validate aimed at an OUT index and a clear aimed at an IN index.
- R3: `rx_ack` is combinational and is 1 when `rx_ep` is an OUT index whose USB-side buffer is not full. It is always 0 for an IN index. An acknowledged `rx_valid` sets the full flag of the USB-side buffer.
- R4: While the USB-side buffer of an OUT endpoint is full, `rx_ack` is 0 and strobes to that endpoint change nothing until a clear command is issued.
- R5: A clear command empties the CPU-side buffer of an OUT endpoint. On a double-buffered endpoint it also inverts the CPU-buffer bit (status bit 1).
- R6: A double-buffered OUT endpoint fills its two buffers alternately, starting with the primary buffer. It accepts two packets before it NAKs.
- R7: A validate command on an IN endpoint sets the full flag of its CPU-side buffer and, when double-buffered, inverts the CPU-buffer bit. A `tx_done` strobe clears the full flag of the USB-side buffer. A `tx_done` strobe to an empty buffer is ignored.
- R8: The data PID bit (status bit 4, 1 = DATA1) toggles on every accepted OUT packet and every completed IN transmission on indices 2–15. It never toggles on indices 0 and 1.
- R9: One cycle after a status command, `stat_valid` is 1 and `stat_byte` holds the image. Bit 7 is stall, which reads 0 because stall state is not held here. Bit 6 is secondary full, bit 5 primary full, bit 4 data PID, bit 3 overwrite, bit 2 setup received, bit 1 CPU buffer, and bit 0 is 0. Reading the image changes no state.
- R10: On index 0, a packet with `rx_setup` set is accepted even while the buffer is full, and it sets the setup bit. If the buffer was already full it also sets the overwrite bit. A clear command on index 0 resets both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code: high nibble is the operation, low nibble is the endpoint index |
| stat_valid | output | 1 | Status image valid, one cycle after a status command |
| stat_byte | output | 8 | Status image of the addressed endpoint |
| rx_valid | input | 1 | Complete OUT packet strobe |
| rx_ep | input | 4 | Endpoint index of the OUT packet |
| rx_setup | input | 1 | OUT packet is a setup packet |
| rx_ack | output | 1 | 1 = accept, 0 = NAK for `rx_ep` |
| tx_done | input | 1 | IN transmission complete strobe |
| tx_ep | input | 4 | Endpoint index of the finished transmission |

## Verification
The bench goes after the lock on a full OUT buffer. A design that wrongly kept acknowledging would overwrite data, and the status byte would show it. The bench also covers the ping-pong order on double-buffered endpoints, where a wrong buffer pointer shows up as the wrong full bit or an early NAK. The reserved codes 0x60 and 0x71 and commands sent to the wrong direction must leave the status bytes unchanged, and they would not if the decode were too broad. Finally, the bench checks the setup override on control OUT, the PID toggle that must skip the control endpoints, and repeated status reads that must return identical bytes.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;

    localparam logic [3:0] GRP_VALIDATE = 4'h6;
    localparam logic [3:0] GRP_CLEAR    = 4'h7;
    localparam logic [3:0] GRP_STATUS   = 4'hD;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_VALIDATE,
        OP_CLEAR,
        OP_STATUS
    } cmd_op_e;

    typedef struct packed {
        logic [1:0] full;     // [0] primary, [1] secondary
        logic       pid;      // next data PID
        logic       ovw;      // setup overwrote a full buffer
        logic       setup;    // setup packet received
        logic       cpu_buf;  // buffer owned by CPU side
        logic       usb_ptr;  // buffer used by USB side
    } ep_state_t;

    function automatic cmd_op_e decode_op(input logic [7:0] code);
        cmd_op_e op;
        op = OP_NONE;
        case (code[7:4])
            GRP_VALIDATE: if (code[3:0] != 4'h0) op = OP_VALIDATE;
            GRP_CLEAR:    if (code[3:0] != 4'h1) op = OP_CLEAR;
            GRP_STATUS:   op = OP_STATUS;
            default:      op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic logic [7:0] status_image(input ep_state_t s);
        return {1'b0, s.full[1], s.full[0], s.pid, s.ovw, s.setup, s.cpu_buf, 1'b0};
    endfunction

endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
    import ep_cmd_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    output cmd_op_e         op,
    output logic [EP_W-1:0] idx
);
    always_comb begin
        op  = cmd_valid ? decode_op(cmd_code) : OP_NONE;
        idx = cmd_code[EP_W-1:0];
    end
endmodule

// File: rtl/ep_state_unit.sv
module ep_state_unit
    import ep_cmd_pkg::*;
#(
    parameter bit IS_IN   = 1'b0,
    parameter bit IS_DBL  = 1'b0,
    parameter bit IS_CTRL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      do_val,
    input  logic      do_clr,
    input  logic      rx_take,
    input  logic      rx_setup,
    input  logic      tx_hit,
    output ep_state_t st,
    output logic      usb_full
);
    ep_state_t st_n;
    logic      tx_take;

    assign usb_full = st.full[st.usb_ptr];
    assign tx_take  = tx_hit && IS_IN && usb_full;

    always_comb begin
        st_n = st;
        if (rx_take) begin
            if (st.full[st.usb_ptr]) st_n.ovw = 1'b1;
            st_n.full[st.usb_ptr] = 1'b1;
            if (rx_setup) st_n.setup = 1'b1;
            if (IS_DBL)   st_n.usb_ptr = ~st.usb_ptr;
            if (!IS_CTRL) st_n.pid = ~st.pid;
        end
        if (tx_take) begin
            st_n.full[st.usb_ptr] = 1'b0;
            if (IS_DBL)   st_n.usb_ptr = ~st.usb_ptr;
            if (!IS_CTRL) st_n.pid = ~st.pid;
        end
        if (do_val && IS_IN) begin
            st_n.full[st.cpu_buf] = 1'b1;
            if (IS_DBL) st_n.cpu_buf = ~st.cpu_buf;
        end
        if (do_clr && !IS_IN) begin
            st_n.full[st.cpu_buf] = 1'b0;
            st_n.setup = 1'b0;
            st_n.ovw   = 1'b0;
            if (IS_DBL) st_n.cpu_buf = ~st.cpu_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end
endmodule

// File: rtl/ep_buf_cmd_ctrl.sv
module ep_buf_cmd_ctrl
    import ep_cmd_pkg::*;
#(
    parameter int          NUM_EP   = 16,
    parameter logic [15:0] IN_MASK  = 16'hAAAA,
    parameter logic [15:0] DBL_MASK = 16'hF000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output logic       stat_valid,
    output logic [7:0] stat_byte,
    input  logic       rx_valid,
    input  logic [3:0] rx_ep,
    input  logic       rx_setup,
    output logic       rx_ack,
    input  logic       tx_done,
    input  logic [3:0] tx_ep
);
    localparam int EP_W = $clog2(NUM_EP);

    cmd_op_e                 op;
    logic [EP_W-1:0]         idx;
    ep_state_t               st       [NUM_EP];
    logic [NUM_EP-1:0]       usb_full;
    logic [2*NUM_EP-1:0]     full_vec;

    ep_cmd_decode #(.EP_W(EP_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .op        (op),
        .idx       (idx)
    );

    always_comb begin
        rx_ack = !IN_MASK[rx_ep] &&
                 (!usb_full[rx_ep[EP_W-1:0]] || (rx_setup && rx_ep == 4'd0));
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic sel;
        assign sel = (idx == EP_W'(i));

        ep_state_unit #(
            .IS_IN   (IN_MASK[i]),
            .IS_DBL  (DBL_MASK[i]),
            .IS_CTRL (i < 2)
        ) u_ep (
            .clk      (clk),
            .rst      (rst),
            .do_val   (op == OP_VALIDATE && sel),
            .do_clr   (op == OP_CLEAR && sel),
            .rx_take  (rx_valid && rx_ack && rx_ep == 4'(i)),
            .rx_setup (rx_setup && i == 0),
            .tx_hit   (tx_done && tx_ep == 4'(i)),
            .st       (st[i]),
            .usb_full (usb_full[i])
        );

        assign full_vec[2*i +: 2] = st[i].full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid <= 1'b0;
            stat_byte  <= '0;
        end else begin
            stat_valid <= (op == OP_STATUS);
            if (op == OP_STATUS) stat_byte <= status_image(st[idx]);
        end
    end
endmodule

// File: rtl/ep_buf_cmd_chk.sv
module ep_buf_cmd_chk #(
    parameter int          NUM_EP  = 16,
    parameter logic [15:0] IN_MASK = 16'hAAAA
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [7:0]          cmd_code,
    input logic                stat_valid,
    input logic [7:0]          stat_byte,
    input logic                rx_valid,
    input logic [3:0]          rx_ep,
    input logic                rx_ack,
    input logic                tx_done,
    input logic [2*NUM_EP-1:0] full_vec
);
    logic bad_code;
    assign bad_code = !((cmd_code[7:4] == 4'h6 && cmd_code[3:0] != 4'h0) ||
                        (cmd_code[7:4] == 4'h7 && cmd_code[3:0] != 4'h1));

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (full_vec == '0 && !stat_valid));

    a_r2_bad_code_no_change: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && bad_code && !rx_valid && !tx_done |=> $stable(full_vec));

    a_r3_in_never_acked: assert property (@(posedge clk) disable iff (rst)
        IN_MASK[rx_ep] |-> !rx_ack);

    a_r4_nak_no_change: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ack && !cmd_valid && !tx_done |=> $stable(full_vec));

    a_r9_status_latency: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code[7:4] == 4'hD |=> stat_valid);

    a_r9_fixed_bits_zero: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_byte[0] == 1'b0 && stat_byte[7] == 1'b0));
endmodule

bind ep_buf_cmd_ctrl ep_buf_cmd_chk #(.NUM_EP(NUM_EP), .IN_MASK(IN_MASK)) u_chk (.*);

// File: tb/ep_buf_cmd_ctrl_test.sv
module ep_buf_cmd_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       stat_valid;
    logic [7:0] stat_byte;
    logic       rx_valid = 1'b0;
    logic [3:0] rx_ep = '0;
    logic       rx_setup = 1'b0;
    logic       rx_ack;
    logic       tx_done = 1'b0;
    logic [3:0] tx_ep = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ep_buf_cmd_ctrl uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stat_is(input string req, input logic [3:0] ep, input logic [7:0] exp);
        send_cmd({4'hD, ep});
        chk({req, " stat_valid"}, {7'd0, stat_valid}, 8'd1);
        chk(req, stat_byte, exp);
    endtask

    task automatic rx_pkt(input string req, input logic [3:0] ep, input logic setup,
                          input logic exp_ack);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_ep    = ep;
        rx_setup = setup;
        #1;
        chk({req, " rx_ack"}, {7'd0, rx_ack}, {7'd0, exp_ack});
        @(negedge clk);
        rx_valid = 1'b0;
        rx_setup = 1'b0;
    endtask

    task automatic tx_pkt(input logic [3:0] ep);
        @(negedge clk);
        tx_done = 1'b1;
        tx_ep   = ep;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 stat_valid after reset", {7'd0, stat_valid}, 8'd0);
        stat_is("R1 ep0", 4'd0, 8'h00);
        stat_is("R1 ep5", 4'd5, 8'h00);
        stat_is("R1 ep15", 4'd15, 8'h00);
    endtask

    task automatic t_out_single;
        rx_pkt("R3 ep2 first", 4'd2, 1'b0, 1'b1);
        stat_is("R3 R8 ep2 full pid1", 4'd2, 8'h30);
        rx_pkt("R4 ep2 locked", 4'd2, 1'b0, 1'b0);
        stat_is("R4 ep2 unchanged", 4'd2, 8'h30);
        stat_is("R9 repeat read same", 4'd2, 8'h30);
        send_cmd(8'h72);
        stat_is("R5 ep2 cleared", 4'd2, 8'h10);
        rx_pkt("R5 ep2 reopened", 4'd2, 1'b0, 1'b1);
        send_cmd(8'h72);
        stat_is("R8 ep2 pid back", 4'd2, 8'h00);
    endtask

    task automatic t_ignore;
        rx_pkt("R8 ep0 normal", 4'd0, 1'b0, 1'b1);
        stat_is("R8 ep0 no pid toggle", 4'd0, 8'h20);
        send_cmd(8'h60);
        send_cmd(8'h71);
        send_cmd(8'h00);
        send_cmd(8'hE5);
        send_cmd(8'h62);
        send_cmd(8'h73);
        stat_is("R2 ep0 untouched", 4'd0, 8'h20);
        stat_is("R2 ep1 untouched", 4'd1, 8'h00);
        stat_is("R2 ep2 validate ignored", 4'd2, 8'h00);
        stat_is("R2 ep3 clear ignored", 4'd3, 8'h00);
        send_cmd(8'h70);
        stat_is("R5 ep0 cleared", 4'd0, 8'h00);
    endtask

    task automatic t_out_double;
        rx_pkt("R6 ep12 pkt1", 4'd12, 1'b0, 1'b1);
        stat_is("R6 ep12 primary", 4'd12, 8'h30);
        rx_pkt("R6 ep12 pkt2", 4'd12, 1'b0, 1'b1);
        stat_is("R6 ep12 both", 4'd12, 8'h60);
        rx_pkt("R4 R6 ep12 pkt3 nak", 4'd12, 1'b0, 1'b0);
        stat_is("R4 ep12 unchanged", 4'd12, 8'h60);
        send_cmd(8'h7C);
        stat_is("R5 ep12 swap", 4'd12, 8'h42);
        rx_pkt("R6 ep12 refill primary", 4'd12, 1'b0, 1'b1);
        stat_is("R6 ep12 refilled", 4'd12, 8'h72);
        send_cmd(8'h7C);
        stat_is("R5 ep12 swap back", 4'd12, 8'h30);
    endtask

    task automatic t_in_single;
        rx_pkt("R3 ep3 IN nak", 4'd3, 1'b0, 1'b0);
        send_cmd(8'h63);
        stat_is("R7 ep3 loaded", 4'd3, 8'h20);
        tx_pkt(4'd3);
        stat_is("R7 R8 ep3 sent", 4'd3, 8'h10);
        tx_pkt(4'd3);
        stat_is("R7 ep3 empty tx ignored", 4'd3, 8'h10);
        send_cmd(8'h61);
        stat_is("R7 ep1 loaded", 4'd1, 8'h20);
        tx_pkt(4'd1);
        stat_is("R8 ep1 no pid toggle", 4'd1, 8'h00);
    endtask

    task automatic t_in_double;
        send_cmd(8'h6D);
        stat_is("R7 ep13 load1", 4'd13, 8'h22);
        send_cmd(8'h6D);
        stat_is("R7 ep13 load2", 4'd13, 8'h60);
        tx_pkt(4'd13);
        stat_is("R7 ep13 tx1", 4'd13, 8'h50);
        tx_pkt(4'd13);
        stat_is("R7 ep13 tx2", 4'd13, 8'h00);
    endtask

    task automatic t_setup;
        rx_pkt("R10 setup1", 4'd0, 1'b1, 1'b1);
        stat_is("R10 setup bit", 4'd0, 8'h24);
        rx_pkt("R10 setup over full", 4'd0, 1'b1, 1'b1);
        stat_is("R10 overwrite bit", 4'd0, 8'h2C);
        rx_pkt("R4 ep0 normal nak", 4'd0, 1'b0, 1'b0);
        send_cmd(8'h70);
        stat_is("R10 clear resets", 4'd0, 8'h00);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_out_single;
        t_ignore;
        t_out_double;
        t_in_single;
        t_in_double;
        t_setup;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule